// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of an 8-bit timer, with the counter it watches. A free-running counter steps once for every cycle in which the tick enable is high. The waveform mode picks how it counts: it can wrap upward, clear itself on a compare hit, or climb to the top value and then descend to zero. Each tick, an equality comparator checks the counter against an active compare value. A hit raises a sticky compare flag, which serves as an interrupt request. A hit also moves the waveform pin according to a 2-bit output mode.

Software reaches the channel through a small register port. Address 0 is the counter, address 1 is the compare value and address 2 is the flag. In the two PWM modes, a write to the compare value lands in a shadow register. That shadow is copied to the active comparator only at the turning point of the count, so a pulse is never cut short or made lopsided. In the non-PWM modes the write takes effect at once.

Two special controls are provided. A force strobe, honoured only in the non-PWM modes, applies the pin action without touching the flag or the counter. Any software write to the counter masks the comparator for the next tick, so loading the counter with the compare value does not produce a hit.

Top module: `tcmp_channel`

## Requirements
- R1: After reset the counter, the compare value, the flag and the pin are all 0.
- R2: Waveform mode 00 counts up by one per tick and wraps from 255 to 0. In every mode the counter holds when the tick is low and there is no counter write.
- R3: Waveform mode 10 clears the counter to 0 on the tick that produces a compare hit. Otherwise it counts up.
- R4: Waveform mode 01 counts up to 255 and then down to 0, turning on the next tick at each end. For example, the sequence runs 254, 255, 254 and 1, 0, 1. Leaving this mode resets the direction to up.
- R5: A hit happens on a tick when the counter equals the active compare value, and it sets the flag. Writing a value with bit 0 = 1 to address 2 clears the flag, writing bit 0 = 0 leaves it unchanged, and a hit in the same cycle wins. Address 2 reads back the flag in bit 0.
- R6: In modes 00 and 10, a write to address 1 changes the active compare value from the next cycle on.
- R7: The PWM modes are those with waveform bit 0 = 1. In these modes a write to address 1 goes only to the shadow register, which is what address 1 reads back. The shadow is copied to the active value on the tick at count 255: in mode 11 always, in mode 01 only while counting up.
- R8: In modes 00 and 10, a hit acts on the pin according to the output mode: 00 leaves it unchanged, 01 toggles it, 10 clears it and 11 sets it.
- R9: A force strobe in modes 00 and 10 applies the R8 action to the pin, leaves the flag alone and does not alter the counter. In the PWM modes the strobe is ignored.
- R10: After a write to address 0, the next tick produces no hit, however many idle cycles pass before that tick. Only that single tick is masked.
- R11: In mode 11, output mode 10 sets the pin at the wrap from 255 to 0 and clears it on a hit. Output mode 11 does the opposite. When both happen on one tick, the wrap action wins.
- R12: In mode 01, output mode 10 clears the pin on a hit while counting up and sets it on a hit while counting down. Output mode 11 does the opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer advance enable |
| wave_sel | input | 2 | Waveform mode: 00 normal, 01 phase-correct PWM, 10 clear on hit, 11 fast PWM |
| out_mode | input | 2 | Pin action: 00 none, 01 toggle, 10 clear, 11 set |
| force_cmp | input | 1 | Forced compare strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 counter, 1 compare, 2 flag |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | W | Read data |
| cnt_q | output | W | Counter value |
| cmp_flag | output | 1 | Compare flag / interrupt request |
| wave_out | output | 1 | Waveform pin |

## Verification
The bench builds the channel with the default width of 8. This keeps a full climb from 0 to 255, a complete up-and-down period of the phase-correct mode and a shadow reload at the wrap within a few hundred ticks. At this width the turning points at 0 and 255, a reload colliding with a hit, and a counter write landing right on the compare value can all be steered into directly. This lets every cycle be compared against the bench's own model.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [1:0] {
    WV_NORMAL = 2'b00,
    WV_PHASE  = 2'b01,
    WV_CTC    = 2'b10,
    WV_FAST   = 2'b11
  } wave_e;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } omode_e;

  localparam logic [1:0] ADDR_CNT = 2'd0;
  localparam logic [1:0] ADDR_CMP = 2'd1;
  localparam logic [1:0] ADDR_FLG = 2'd2;

  // PWM modes carry bit 0 set
  function automatic logic is_pwm(wave_e w);
    return (w == WV_PHASE) || (w == WV_FAST);
  endfunction

  // non-PWM hit or forced compare
  function automatic logic pin_plain(omode_e m, logic cur);
    logic r;
    case (m)
      OM_TOGGLE: r = ~cur;
      OM_CLEAR:  r = 1'b0;
      OM_SET:    r = 1'b1;
      default:   r = cur;
    endcase
    return r;
  endfunction

  // PWM hit; rising says the count is going up
  function automatic logic pin_pwm_hit(omode_e m, logic rising, logic cur);
    logic r;
    case (m)
      OM_CLEAR: r = ~rising;
      OM_SET:   r = rising;
      default:  r = cur;
    endcase
    return r;
  endfunction

  // fast PWM wrap to zero
  function automatic logic pin_pwm_wrap(omode_e m, logic cur);
    logic r;
    case (m)
      OM_CLEAR: r = 1'b1;
      OM_SET:   r = 1'b0;
      default:  r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter
  import tcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wave_e        wave,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  input  logic         ctc_clear,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic         top_evt,
  output logic         wrap_evt
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] step_up(logic [W-1:0] v);
    return v + ONE;
  endfunction

  // returns {direction, next value}
  function automatic logic [W:0] step_phase(logic up, logic [W-1:0] v);
    logic [W:0] r;
    if (up) begin
      if (v == MAXV) r = {1'b0, MAXV - ONE};
      else           r = {1'b1, v + ONE};
    end else begin
      if (v == '0)   r = {1'b1, ONE};
      else           r = {1'b0, v - ONE};
    end
    return r;
  endfunction

  logic [W-1:0] cnt_n;
  logic         dir_n;
  logic [W:0]   ph;
  logic         adv;

  assign adv      = tick && !wr_cnt;
  assign ph       = step_phase(dir_up, cnt);
  assign top_evt  = adv && (wave == WV_PHASE) && dir_up && (cnt == MAXV);
  assign wrap_evt = adv && (wave == WV_FAST) && (cnt == MAXV);

  always_comb begin
    cnt_n = cnt;
    dir_n = (wave == WV_PHASE) ? dir_up : 1'b1;
    if (wr_cnt) begin
      cnt_n = wr_val;
    end else if (tick) begin
      unique case (wave)
        WV_NORMAL, WV_FAST: cnt_n = step_up(cnt);
        WV_CTC:             cnt_n = ctc_clear ? '0 : step_up(cnt);
        WV_PHASE: begin
          cnt_n = ph[W-1:0];
          dir_n = ph[W];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      cnt    <= cnt_n;
      dir_up <= dir_n;
    end
  end

endmodule

// File: rtl/tcmp_ocr.sv
module tcmp_ocr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_val,
  input  logic         load_evt,
  output logic [W-1:0] ocr_buf,
  output logic [W-1:0] ocr_act
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (wr_cmp) ocr_buf <= wr_val;
      if (load_evt)             ocr_act <= ocr_buf;
      else if (wr_cmp && !pwm)  ocr_act <= wr_val;
    end
  end

endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] ocr_act,
  output logic         match_evt
);

  logic blk_pend;

  function automatic logic equal_w(logic [W-1:0] a, logic [W-1:0] b);
    return a == b;
  endfunction

  assign match_evt = tick && !wr_cnt && !blk_pend && equal_w(cnt, ocr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       blk_pend <= 1'b0;
    else if (wr_cnt)  blk_pend <= 1'b1;
    else if (tick)    blk_pend <= 1'b0;
  end

endmodule

// File: rtl/tcmp_wavegen.sv
module tcmp_wavegen
  import tcmp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  wave_e  wave,
  input  omode_e omode,
  input  logic   match_evt,
  input  logic   force_req,
  input  logic   dir_up,
  input  logic   wrap_evt,
  output logic   pin
);

  logic pin_n;

  always_comb begin
    pin_n = pin;
    unique case (wave)
      WV_NORMAL, WV_CTC: begin
        if (match_evt || force_req) pin_n = pin_plain(omode, pin);
      end
      WV_FAST: begin
        if (wrap_evt)       pin_n = pin_pwm_wrap(omode, pin);
        else if (match_evt) pin_n = pin_pwm_hit(omode, 1'b1, pin);
      end
      WV_PHASE: begin
        if (match_evt) pin_n = pin_pwm_hit(omode, dir_up, pin);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_n;
  end

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
  import tcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   wave_sel,
  input  logic [1:0]   out_mode,
  input  logic         force_cmp,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] cnt_q,
  output logic         cmp_flag,
  output logic         wave_out
);

  wave_e        wave;
  omode_e       omode;
  logic         pwm;
  logic         wr_cnt, wr_cmp, wr_flg;
  logic         match_evt, load_evt, top_evt, wrap_evt, dir_up;
  logic [W-1:0] ocr_buf, ocr_act;

  assign wave   = wave_e'(wave_sel);
  assign omode  = omode_e'(out_mode);
  assign pwm    = is_pwm(wave);
  assign wr_cnt = wr_en && (wr_addr == ADDR_CNT);
  assign wr_cmp = wr_en && (wr_addr == ADDR_CMP);
  assign wr_flg = wr_en && (wr_addr == ADDR_FLG);
  assign load_evt = top_evt || wrap_evt;

  tcmp_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wave      (wave),
    .wr_cnt    (wr_cnt),
    .wr_val    (wr_data),
    .ctc_clear (match_evt && (wave == WV_CTC)),
    .cnt       (cnt_q),
    .dir_up    (dir_up),
    .top_evt   (top_evt),
    .wrap_evt  (wrap_evt)
  );

  tcmp_ocr #(.W(W)) u_ocr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm      (pwm),
    .wr_cmp   (wr_cmp),
    .wr_val   (wr_data),
    .load_evt (load_evt),
    .ocr_buf  (ocr_buf),
    .ocr_act  (ocr_act)
  );

  tcmp_match #(.W(W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_cnt    (wr_cnt),
    .cnt       (cnt_q),
    .ocr_act   (ocr_act),
    .match_evt (match_evt)
  );

  tcmp_wavegen u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .wave      (wave),
    .omode     (omode),
    .match_evt (match_evt),
    .force_req (force_cmp && !pwm),
    .dir_up    (dir_up),
    .wrap_evt  (wrap_evt),
    .pin       (wave_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cmp_flag <= 1'b0;
    else if (match_evt)               cmp_flag <= 1'b1;
    else if (wr_flg && wr_data[0])    cmp_flag <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      ADDR_CNT: rd_data = cnt_q;
      ADDR_CMP: rd_data = ocr_buf;
      ADDR_FLG: rd_data = {{(W-1){1'b0}}, cmp_flag};
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/tcmp_channel_chk.sv
module tcmp_channel_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [1:0]   wave_sel,
  input logic         force_cmp,
  input logic [W-1:0] cnt_q,
  input logic         cmp_flag,
  input logic         match_evt,
  input logic         load_evt,
  input logic [W-1:0] ocr_act
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic wr_cnt_c;
  assign wr_cnt_c = wr_en && (wr_addr == 2'd0);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_sel == 2'b00 && tick && !wr_cnt_c && cnt_q == MAXV) |=> (cnt_q == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt_c) |=> $stable(cnt_q));

  p_ctc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_sel == 2'b10 && match_evt) |=> (cnt_q == '0));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag);

  p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_evt && !cmp_flag) |=> !cmp_flag);

  p_pwm_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_sel[0] && !load_evt) |=> $stable(ocr_act));

  p_force_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp && !wave_sel[0] && !match_evt && !cmp_flag) |=> !cmp_flag);

  p_force_nocnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp && !tick && !wr_cnt_c) |=> $stable(cnt_q));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_cnt_c) |-> !match_evt);

endmodule

bind tcmp_channel tcmp_channel_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wave_sel  (wave_sel),
  .force_cmp (force_cmp),
  .cnt_q     (cnt_q),
  .cmp_flag  (cmp_flag),
  .match_evt (match_evt),
  .load_evt  (load_evt),
  .ocr_act   (ocr_act)
);

// File: tb/test_tcmp_channel.sv
`timescale 1ns/1ps
module test_tcmp_channel;

  localparam int W   = 8;
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick, force_cmp, wr_en;
  logic [1:0]   wave_sel, out_mode, wr_addr, rd_addr;
  logic [W-1:0] wr_data, rd_data, cnt_q;
  logic         cmp_flag, wave_out;

  always #2.5 clk = ~clk;

  tcmp_channel #(.W(W)) i_tcmp_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wave_sel(wave_sel),
    .out_mode(out_mode), .force_cmp(force_cmp), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cnt_q(cnt_q), .cmp_flag(cmp_flag),
    .wave_out(wave_out)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";

  // reference state
  int m_cnt, m_dir, m_buf, m_act, m_flag, m_pin, m_blk;

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_dir = 1; m_buf = 0; m_act = 0;
    m_flag = 0; m_pin = 0; m_blk = 0;
  endtask

  task automatic model_step();
    bit wc, wp, wf, pwm, hit, at_top, wrap;
    int nc, nd, nb, na, nf, np, nk, om;
    wc  = wr_en && wr_addr == 2'd0;
    wp  = wr_en && wr_addr == 2'd1;
    wf  = wr_en && wr_addr == 2'd2;
    pwm = (wave_sel == 2'b01) || (wave_sel == 2'b11);
    om  = int'(out_mode);
    hit = tick && !wc && (m_blk == 0) && (m_cnt == m_act);
    wrap   = tick && !wc && m_cnt == TOP && wave_sel == 2'b11;
    at_top = tick && !wc && m_cnt == TOP && wave_sel == 2'b01 && m_dir == 1;
    nc = m_cnt; nd = (wave_sel == 2'b01) ? m_dir : 1;
    nb = m_buf; na = m_act; nf = m_flag; np = m_pin; nk = m_blk;
    if (wc) nc = int'(wr_data);
    else if (tick) begin
      case (wave_sel)
        2'b00, 2'b11: nc = (m_cnt + 1) % (TOP + 1);
        2'b10: nc = hit ? 0 : (m_cnt + 1) % (TOP + 1);
        default: begin
          if (m_dir == 1) begin
            if (m_cnt == TOP) begin nc = TOP - 1; nd = 0; end
            else nc = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin nc = 1; nd = 1; end
            else nc = m_cnt - 1;
          end
        end
      endcase
    end
    if (wp) begin nb = int'(wr_data); if (!pwm) na = int'(wr_data); end
    if (wrap || at_top) na = m_buf;
    if (wf && wr_data[0]) nf = 0;
    if (hit) nf = 1;
    if (wc) nk = 1; else if (tick) nk = 0;
    if (!pwm) begin
      if (hit || force_cmp) begin
        if (om == 1) np = 1 - m_pin;
        else if (om == 2) np = 0;
        else if (om == 3) np = 1;
      end
    end else if (wave_sel == 2'b11) begin
      if (wrap) begin
        if (om == 2) np = 1; else if (om == 3) np = 0;
      end else if (hit) begin
        if (om == 2) np = 0; else if (om == 3) np = 1;
      end
    end else if (hit) begin
      if (om == 2) np = (m_dir == 1) ? 0 : 1;
      else if (om == 3) np = (m_dir == 1) ? 1 : 0;
    end
    m_cnt = nc; m_dir = nd; m_buf = nb; m_act = na;
    m_flag = nf; m_pin = np; m_blk = nk;
  endtask

  function automatic int model_read();
    case (rd_addr)
      2'd0: return m_cnt;
      2'd1: return m_buf;
      2'd2: return m_flag;
      default: return 0;
    endcase
  endfunction

  task automatic cyc();
    int exp_rd;
    @(posedge clk);
    model_step();
    exp_rd = model_read();
    #1;
    chk(cur_req, int'(cnt_q), m_cnt, "counter");
    chk(cur_req, int'(cmp_flag), m_flag, "flag");
    chk(cur_req, int'(wave_out), m_pin, "pin");
    chk(cur_req, int'(rd_data), exp_rd, "read data");
    wr_en = 1'b0; tick = 1'b0; force_cmp = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1'b1; cyc(); end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    int p, c;
    rst_n = 1'b0; tick = 1'b0; force_cmp = 1'b0; wr_en = 1'b0;
    wave_sel = 2'b00; out_mode = 2'b00; wr_addr = 2'd0; wr_data = '0;
    rd_addr = 2'd1;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", int'(cnt_q), 0, "counter");
    chk("R1", int'(rd_data), 0, "compare");
    chk("R1", int'(cmp_flag), 0, "flag");
    chk("R1", int'(wave_out), 0, "pin");
    rst_n = 1'b1;

    // R2 normal counting, wrap and hold
    cur_req = "R2";
    wr(2'd1, 8'h80);
    for (int i = 0; i < 300; i++) begin tick = (i % 3 != 0); cyc(); end
    wr(2'd0, 8'hFE);
    ticks(2);
    chk("R2", int'(cnt_q), 0, "wrap to zero");
    idle(3);
    chk("R2", int'(cnt_q), 0, "hold without tick");

    // R5 flag set and clear
    cur_req = "R5";
    wr(2'd2, 1);
    chk("R5", int'(cmp_flag), 0, "flag cleared by one");
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h0E);
    ticks(3);
    chk("R5", int'(cmp_flag), 1, "flag set by hit");
    wr(2'd2, 0);
    chk("R5", int'(cmp_flag), 1, "zero write keeps flag");
    rd_addr = 2'd2; idle(1); rd_addr = 2'd1;

    // R6 immediate compare, R8 pin actions
    cur_req = "R8";
    wr(2'd1, 5);
    for (int om = 3; om >= 0; om--) begin
      out_mode = 2'(om);
      wr(2'd2, 1);
      p = int'(wave_out);
      wr(2'd0, 3);
      ticks(3);
      chk("R6", int'(cmp_flag), 1, "new compare in use");
      case (om)
        3: chk("R8", int'(wave_out), 1, "set on hit");
        2: chk("R8", int'(wave_out), 0, "clear on hit");
        1: chk("R8", int'(wave_out), 1 - p, "toggle on hit");
        default: chk("R8", int'(wave_out), p, "no action");
      endcase
    end

    // R9 forced compare
    cur_req = "R9";
    out_mode = 2'b01;
    wr(2'd2, 1);
    p = int'(wave_out); c = int'(cnt_q);
    force_cmp = 1'b1; cyc();
    chk("R9", int'(wave_out), 1 - p, "force toggles pin");
    chk("R9", int'(cmp_flag), 0, "force leaves flag");
    chk("R9", int'(cnt_q), c, "force leaves counter");
    out_mode = 2'b11;
    force_cmp = 1'b1; tick = 1'b1; cyc();
    chk("R9", int'(wave_out), 1, "force sets pin");
    chk("R9", int'(cnt_q), (c + 1) % 256, "counter steps normally");

    // R10 blocking after counter write
    cur_req = "R10";
    wr(2'd1, 8'h20);
    wr(2'd2, 1);
    wr(2'd0, 8'h20);
    idle(5);
    ticks(1);
    chk("R10", int'(cmp_flag), 0, "hit masked after write");
    wr(2'd0, 8'h1F);
    ticks(2);
    chk("R10", int'(cmp_flag), 1, "mask lasts one tick");

    // R3 clear on hit
    cur_req = "R3";
    wave_sel = 2'b10;
    wr(2'd1, 9);
    wr(2'd0, 0);
    ticks(10);
    chk("R3", int'(cnt_q), 0, "cleared on hit");
    ticks(2);
    chk("R3", int'(cnt_q), 2, "counts on after clear");

    // R7 / R11 fast PWM shadow and pin
    cur_req = "R7";
    wave_sel = 2'b00;
    wr(2'd1, 8'h40);
    wave_sel = 2'b11; out_mode = 2'b10;
    wr(2'd1, 8'hC0);
    chk("R7", int'(rd_data), 8'hC0, "shadow read back");
    wr(2'd2, 1);
    wr(2'd0, 8'h3E);
    ticks(3);
    chk("R7", int'(cmp_flag), 1, "old compare still active");
    cur_req = "R11";
    ticks(8'hBF);
    chk("R11", int'(cnt_q), 0, "wrapped");
    chk("R11", int'(wave_out), 1, "set at wrap");
    wr(2'd2, 1);
    wr(2'd0, 8'hBE);
    ticks(3);
    chk("R7", int'(cmp_flag), 1, "shadow loaded at wrap");
    chk("R11", int'(wave_out), 0, "clear on hit");
    p = int'(wave_out);
    force_cmp = 1'b1; cyc();
    chk("R9", int'(wave_out), p, "force ignored in PWM");
    out_mode = 2'b11;
    ticks(300);

    // R4 / R12 phase-correct
    cur_req = "R4";
    out_mode = 2'b10;
    wave_sel = 2'b00; idle(1);
    wave_sel = 2'b01;
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hFE);
    ticks(3);
    chk("R4", int'(cnt_q), 8'hFD, "turns down at top");
    wr(2'd0, 2);
    ticks(4);
    chk("R4", int'(cnt_q), 2, "turns up at bottom");
    cur_req = "R12";
    wr(2'd0, 8'h7E);
    ticks(3);
    chk("R12", int'(wave_out), 0, "clear on up hit");
    wr(2'd0, 8'hFE);
    ticks(129);
    chk("R12", int'(cnt_q), 8'h7F, "descending");
    chk("R12", int'(wave_out), 1, "set on down hit");
    out_mode = 2'b11;
    ticks(600);

    finish_run();
  end

endmodule